// File: doc/BRIEF.md
# I2C Controller Host Register Interface

This block is the processor-facing side of a parallel-bus-to-I2C controller. A host selects one of four registers with a two-bit address and qualifies each access with a read or a write strobe. Two of the registers carry the traffic of interest: the data register, which holds the byte to be shifted out or the byte just taken in, and the control register, which holds the enable, start, stop, acknowledge and mode bits together with the interrupt flag. A third, read-only location returns the status code of the most recent arbitration loss.

The serial engine is not part of this block. It shows up as single-cycle event inputs: an interrupt request, a STOP seen on the bus, a received byte, the own slave address received, and an arbitration loss with its status code. The engine presents the byte that goes with an event on a shared input. The block answers with an interrupt output and a clock-hold signal that keeps the serial clock stretched until the host acknowledges. The acknowledgement is any write to the control register. A transfer-mode input separates byte-at-a-time operation from buffered operation. Buffered operation moves up to 68 bytes per transfer through a buffer that lives outside this block, and the mode decides whether an arbitration loss may overwrite the data register.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `scl_hold` are low.
- R2: A write at address 1 loads the data register, and a read at address 1 returns it. Bit 7 is the first bit on the wire, and a 1 bit stands for a HIGH bus level.
- R3: The control register sits at address 3. Its bit positions are: bit 7 acknowledge enable, bit 6 serial enable, bit 5 START request, bit 4 STOP request, bit 3 interrupt flag, bit 0 mode. A host write stores bits 7, 6, 5, 4 and 0. Bits 2 and 1 always read 0. The value written to bit 3 is ignored.
- R4: An engine interrupt request sets the flag. From the next cycle on, `irq` and `scl_hold` stay high until a control register write.
- R5: Any control register write clears the flag, whatever is written to bit 3. `irq` and `scl_hold` are low in the cycle after that write. If an engine request arrives in the same cycle as the write, the request wins.
- R6: A STOP seen on the bus clears the STOP request bit and leaves the other control bits alone. This also holds when it coincides with a host write that sets the bit.
- R7: An own-address event or a received-byte event loads the engine byte into the data register.
- R8: An arbitration loss with `buf_mode` low loads the engine byte into the data register. Every arbitration loss stores its code in the status register at address 0.
- R9: An arbitration loss with `buf_mode` high leaves the data register unchanged, but the status code is still stored.
- R10: Writes to addresses 0 and 2 have no effect. A read at address 2 returns 0, and `rdata` is 0 whenever `rd_en` is low.
- R11: When an engine load of the data register and a host write at address 1 fall in the same cycle, the engine byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Interrupt to host, high while flag set |
| scl_hold | output | 1 | Stretch serial clock until acknowledged |
| buf_mode | input | 1 | 1 = buffered transfers, 0 = byte mode |
| eng_irq_req | input | 1 | Engine interrupt request |
| eng_stop_seen | input | 1 | STOP detected on bus |
| eng_rx_valid | input | 1 | Byte received |
| eng_own_addr | input | 1 | Own slave address received |
| eng_arb_lost | input | 1 | Arbitration lost |
| eng_arb_code | input | 8 | Status code for the arbitration loss |
| eng_byte | input | 8 | Byte belonging to the engine event |

## Verification
The bench writes all 256 values to the control register while the interrupt flag is set. A design that stored bit 3 from the bus, leaked bits 2 and 1, or failed to clear the flag on acknowledge gives a wrong readback or a stuck `irq`. Arbitration losses are swept over many bytes in both modes, so a design that overwrites the data register in buffered mode, or skips the overwrite in byte mode, shows the wrong byte on readback. The bench also hits each same-cycle collision: a request during an acknowledge, a STOP during a write that sets the STOP bit, and an engine load during a host data write. A design with the wrong priority keeps the wrong value. The bench further checks that `scl_hold` stays high across non-acknowledging accesses, which catches an early release.

// File: rtl/i2c_host_regs.sv
module i2c_host_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       scl_hold,
  input  logic       buf_mode,
  input  logic       eng_irq_req,
  input  logic       eng_stop_seen,
  input  logic       eng_rx_valid,
  input  logic       eng_own_addr,
  input  logic       eng_arb_lost,
  input  logic [7:0] eng_arb_code,
  input  logic [7:0] eng_byte
);

  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd3;

  logic [7:0] data_q, stat_q;
  logic       ack_en, ser_en, start_q, stop_q, flag_q, mode_q;

  wire wr_data  = wr_en && addr == A_DATA;
  wire wr_ctrl  = wr_en && addr == A_CTRL;
  wire eng_load = eng_own_addr || eng_rx_valid || (eng_arb_lost && !buf_mode);

  wire [7:0] ctrl_rd = {ack_en, ser_en, start_q, stop_q, flag_q, 2'b00, mode_q};

  always_ff @(posedge clk) begin
    if (!rst_n)        data_q <= '0;
    else if (eng_load) data_q <= eng_byte;
    else if (wr_data)  data_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            stat_q <= '0;
    else if (eng_arb_lost) stat_q <= eng_arb_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_en  <= 1'b0;
      ser_en  <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ack_en  <= wdata[7];
        ser_en  <= wdata[6];
        start_q <= wdata[5];
        mode_q  <= wdata[0];
      end
      if (eng_stop_seen) stop_q <= 1'b0;
      else if (wr_ctrl)  stop_q <= wdata[4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           flag_q <= 1'b0;
    else if (eng_irq_req) flag_q <= 1'b1;
    else if (wr_ctrl)     flag_q <= 1'b0;
  end

  assign irq      = flag_q;
  assign scl_hold = flag_q;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_STAT:  rdata = stat_q;
        A_DATA:  rdata = data_q;
        A_CTRL:  rdata = ctrl_rd;
        default: rdata = '0;
      endcase
    end
  end

  p_req_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_irq_req |=> (irq && scl_hold));

  p_hold_until_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && !(wr_en && addr == A_CTRL)) |=> scl_hold);

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL && !eng_irq_req) |=> (!irq && !scl_hold));

  p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stop_seen |=> !stop_q);

  p_buf_keeps_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_arb_lost && buf_mode && !eng_rx_valid && !eng_own_addr &&
     !(wr_en && addr == A_DATA)) |=> $stable(data_q));

  p_unused_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CTRL) |-> rdata[2:1] == 2'b00);

  p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 8'h00);

endmodule

// File: tb/i2c_host_regs_tb.sv
module i2c_host_regs_tb_top;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0, buf_mode = 0;
  logic [7:0] wdata = 0, eng_arb_code = 0, eng_byte = 0;
  logic eng_irq_req = 0, eng_stop_seen = 0, eng_rx_valid = 0, eng_own_addr = 0, eng_arb_lost = 0;
  logic [7:0] rdata;
  logic irq, scl_hold;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .scl_hold(scl_hold),
    .buf_mode(buf_mode), .eng_irq_req(eng_irq_req), .eng_stop_seen(eng_stop_seen),
    .eng_rx_valid(eng_rx_valid), .eng_own_addr(eng_own_addr),
    .eng_arb_lost(eng_arb_lost), .eng_arb_code(eng_arb_code), .eng_byte(eng_byte));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cpu_rd(logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1;
    #1 d = rdata;
    rd_en = 0;
  endtask

  task automatic pulse_irq();
    eng_irq_req = 1;
    @(negedge clk);
    eng_irq_req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r, keep;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cpu_rd(0, r); check("R1 status", r, 0);
    cpu_rd(1, r); check("R1 data", r, 0);
    cpu_rd(3, r); check("R1 ctrl", r, 0);
    check("R1 irq", {7'b0, irq}, 0);
    check("R1 hold", {7'b0, scl_hold}, 0);

    // R2 data register sweep
    for (int v = 0; v < 256; v++) begin
      cpu_wr(1, v[7:0]);
      cpu_rd(1, r); check("R2 data rw", r, v[7:0]);
    end

    // R3/R4/R5 control sweep with flag set
    for (int v = 0; v < 256; v++) begin
      pulse_irq();
      check("R4 irq set", {7'b0, irq}, 1);
      check("R4 hold set", {7'b0, scl_hold}, 1);
      cpu_rd(3, r); check("R3 flag visible", {7'b0, r[3]}, 1);
      cpu_wr(3, v[7:0]);
      check("R5 irq cleared", {7'b0, irq}, 0);
      check("R5 hold released", {7'b0, scl_hold}, 0);
      cpu_rd(3, r); check("R3 ctrl layout", r, v[7:0] & 8'hF1);
    end

    // R4 hold survives non-ack accesses
    pulse_irq();
    cpu_wr(1, 8'h5A);
    cpu_wr(0, 8'hFF);
    cpu_rd(3, r);
    @(negedge clk);
    check("R4 hold kept", {7'b0, scl_hold}, 1);
    check("R4 irq kept", {7'b0, irq}, 1);

    // R5 request wins over simultaneous ack
    eng_irq_req = 1;
    cpu_wr(3, 8'h40);
    eng_irq_req = 0;
    check("R5 collision irq", {7'b0, irq}, 1);
    cpu_wr(3, 8'h40);
    check("R5 ack after collision", {7'b0, irq}, 0);

    // R6 stop clears STO only
    cpu_wr(3, 8'hF1);
    eng_stop_seen = 1; @(negedge clk); eng_stop_seen = 0;
    cpu_rd(3, r); check("R6 stop clear", r, 8'hE1);
    eng_stop_seen = 1;
    cpu_wr(3, 8'h10);
    eng_stop_seen = 0;
    cpu_rd(3, r); check("R6 stop beats write", r, 8'h00);

    // R7 own address and received byte
    for (int v = 0; v < 256; v += 17) begin
      eng_byte = v[7:0]; eng_own_addr = 1; @(negedge clk); eng_own_addr = 0;
      cpu_rd(1, r); check("R7 own addr", r, v[7:0]);
      eng_byte = ~v[7:0]; eng_rx_valid = 1; @(negedge clk); eng_rx_valid = 0;
      cpu_rd(1, r); check("R7 rx byte", r, ~v[7:0]);
    end

    // R8/R9 arbitration loss in both modes
    for (int v = 0; v < 256; v += 5) begin
      buf_mode = 0;
      cpu_wr(1, 8'hC3);
      eng_byte = v[7:0]; eng_arb_code = 8'h38 ^ v[7:0]; eng_arb_lost = 1;
      @(negedge clk); eng_arb_lost = 0;
      cpu_rd(1, r); check("R8 byte mode overwrite", r, v[7:0]);
      cpu_rd(0, r); check("R8 status code", r, 8'h38 ^ v[7:0]);
      buf_mode = 1;
      keep = ~v[7:0];
      cpu_wr(1, keep);
      eng_byte = v[7:0] ^ 8'h81; eng_arb_code = v[7:0]; eng_arb_lost = 1;
      @(negedge clk); eng_arb_lost = 0;
      cpu_rd(1, r); check("R9 buffered keeps data", r, keep);
      cpu_rd(0, r); check("R9 status code", r, v[7:0]);
    end
    buf_mode = 0;

    // R10 ignored addresses and idle read
    cpu_wr(1, 8'h66);
    cpu_wr(3, 8'h81);
    cpu_rd(0, keep);
    cpu_wr(0, 8'h99);
    cpu_wr(2, 8'hAA);
    cpu_rd(0, r); check("R10 status write ignored", r, keep);
    cpu_rd(2, r); check("R10 addr2 zero", r, 0);
    cpu_rd(1, r); check("R10 data untouched", r, 8'h66);
    cpu_rd(3, r); check("R10 ctrl untouched", r, 8'h81);
    addr = 1; rd_en = 0; #1 check("R10 idle rdata", rdata, 0);

    // R11 engine load beats host write
    eng_byte = 8'h3C; eng_rx_valid = 1;
    cpu_wr(1, 8'hE7);
    eng_rx_valid = 0;
    cpu_rd(1, r); check("R11 engine wins", r, 8'h3C);

    // R1 reset again after activity
    pulse_irq();
    rst_n = 0; @(negedge clk); rst_n = 1;
    cpu_rd(3, r); check("R1 ctrl after reset", r, 0);
    check("R1 irq after reset", {7'b0, irq}, 0);

    finish_run();
  end
endmodule